// File: doc/BRIEF.md
# Boot Command Line Recognizer

This block listens to a one-way serial command line driven by a host, clocked by the host's bus clock. The line rests at logic 1, and the clock may run for a very long time with nothing but ones on the line. There is no chip-select, so the block finds a frame on its own. It waits for a zero that follows at least one idle one, and takes that zero as bit 0 of the frame. It then shifts in a fixed-length frame, most significant bit first.

Each complete frame, with its CRC, is compared as a whole against three fixed patterns. The result is a one-cycle strobe carrying a 2-bit command code. A controller that serves the boot data uses this strobe to start a transfer or to abandon one. An enable input keeps the recognizer quiet while that service is switched off.

Top module: `boot_cmd_sniffer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `cmd_valid` is 0 and `cmd_code` is 0.
- R2: An unbroken run of ones on `cmd_line`, of any length, never produces a strobe.
- R3: A frame begins at the first 0 sampled after at least one sampled 1. That 0 and the following 47 bits, sampled on rising edges, form the 48-bit frame with the first bit as the MSB. The number of leading idle ones does not affect the result.
- R4: The frame 0x400000000095 yields code 0 (go idle).
- R5: The frame 0x40F0F0F0F0FD yields code 1 (go pre-idle).
- R6: The frame 0x40FFFFFFFAE5 yields code 2 (boot initiation).
- R7: Any other captured frame yields code 3 (error). This includes frames whose second bit is 0 and frames that differ from a known pattern in a single bit.
- R8: For the timing of the strobe, call the rising edge that samples the 48th bit edge N. `cmd_valid` goes high at edge N+1 and stays high for exactly one cycle. Exactly one strobe is produced per frame. `cmd_code` is 0 whenever `cmd_valid` is low.
- R9: After a frame ends, a 0 sampled before any 1 does not start a new frame.
- R10: While `en` is low, the block gives no strobe, even for a complete known frame. Dropping `en` during a frame discards that frame.
- R11: A 0 on the line directly after reset, with no 1 before it, does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Recognizer enable; low forces hunting and no output |
| cmd_line | input | 1 | Serial command line, idle high |
| cmd_valid | output | 1 | One-cycle strobe for a classified frame |
| cmd_code | output | 2 | 0 idle, 1 pre-idle, 2 boot, 3 error; 0 when no strobe |

## Verification
The bench builds the block with its default parameters: a 48-bit frame and the three fixed patterns. This makes the full frame length and the real command encodings reachable directly. Frames are sent after idle runs of different lengths, and near-miss frames are included.

Directed cases cover the following:
- a zero right after reset;
- a zero right after a frame;
- a known frame sent while disabled;
- a frame cut short by dropping the enable.

A strobe counter checks that none of these produces a pulse.

// File: rtl/boot_cmd_sniffer.sv
module boot_cmd_sniffer #(
  parameter int FRAME_BITS = 48,
  parameter logic [FRAME_BITS-1:0] PAT_IDLE = 48'h400000000095,
  parameter logic [FRAME_BITS-1:0] PAT_PRE  = 48'h40F0F0F0F0FD,
  parameter logic [FRAME_BITS-1:0] PAT_BOOT = 48'h40FFFFFFFAE5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       cmd_line,
  output logic       cmd_valid,
  output logic [1:0] cmd_code
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  logic                  capturing;
  logic                  armed;
  logic                  done;
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic [1:0]            match_code;

  wire start_bit = !capturing && armed && !cmd_line;

  always_comb begin
    if (shreg == PAT_IDLE)      match_code = 2'd0;
    else if (shreg == PAT_PRE)  match_code = 2'd1;
    else if (shreg == PAT_BOOT) match_code = 2'd2;
    else                        match_code = 2'd3;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      capturing <= 1'b0;
      armed     <= 1'b0;
      done      <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      cmd_valid <= 1'b0;
      cmd_code  <= 2'd0;
    end else begin
      done      <= 1'b0;
      cmd_valid <= done;
      cmd_code  <= done ? match_code : 2'd0;
      if (start_bit) begin
        capturing <= 1'b1;
        armed     <= 1'b0;
        bit_cnt   <= CNT_W'(1);
        shreg     <= {shreg[FRAME_BITS-2:0], cmd_line};
      end else if (capturing) begin
        shreg <= {shreg[FRAME_BITS-2:0], cmd_line};
        if (bit_cnt == LAST_IDX) begin
          capturing <= 1'b0;
          done      <= 1'b1;
          bit_cnt   <= '0;
        end else begin
          bit_cnt <= bit_cnt + CNT_W'(1);
        end
      end else begin
        armed <= armed | cmd_line;
      end
    end
  end

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R8
  code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> cmd_code == 2'd0);

  // R10
  en_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !cmd_valid && !capturing);

  // R3
  start_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capturing) |-> !$past(cmd_line) && $past(en));

  // R8
  strobe_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !capturing && $past(done));

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < CNT_W'(FRAME_BITS));

endmodule

// File: tb/boot_cmd_sniffer_bench.sv
module boot_cmd_sniffer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic cmd_line = 1'b1;
  logic cmd_valid;
  logic [1:0] cmd_code;

  int checks = 0;
  int failures = 0;
  int pulses = 0;

  always #5 clk = ~clk;

  boot_cmd_sniffer u_boot_cmd_sniffer (
    .clk(clk), .rst_n(rst_n), .en(en), .cmd_line(cmd_line),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code)
  );

  always @(negedge clk) if (cmd_valid) pulses++;

  // {frame, expected code}
  localparam logic [49:0] VECS [0:6] = '{
    {48'h400000000095, 2'd0},
    {48'h40F0F0F0F0FD, 2'd1},
    {48'h40FFFFFFFAE5, 2'd2},
    {48'h4A1234567890, 2'd3},
    {48'h000000000000, 2'd3},
    {48'h400000000094, 2'd3},
    {48'h40FFFFFFFAE4, 2'd3}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); cmd_line = 1'b1;
    end
  endtask

  task automatic send_bits(input logic [47:0] f);
    for (int b = 47; b >= 0; b--) begin
      @(negedge clk); cmd_line = f[b];
    end
  endtask

  // sends frame; checks strobe at edge N+1 and its single-cycle width
  task automatic run_frame(input logic [47:0] f, input logic [1:0] exp, input string req);
    int p0;
    p0 = pulses;
    send_bits(f);
    @(negedge clk); cmd_line = 1'b1;
    check(cmd_valid == 1'b0, "R8 no early strobe", int'(cmd_valid), 0);
    @(negedge clk);
    check(cmd_valid == 1'b1, "R8 strobe at N+1", int'(cmd_valid), 1);
    check(cmd_code == exp, req, int'(cmd_code), int'(exp));
    @(negedge clk);
    check(cmd_valid == 1'b0 && cmd_code == 2'd0, "R8 single cycle", int'(cmd_valid), 0);
    check(pulses == p0 + 1, "R8 one strobe", pulses - p0, 1);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int p0;
    // R1 and R11: zero on line during and after reset
    cmd_line = 1'b0;
    repeat (3) @(negedge clk);
    check(cmd_valid == 1'b0 && cmd_code == 2'd0, "R1 reset state", int'(cmd_code), 0);
    rst_n = 1'b1; en = 1'b1;
    @(negedge clk);
    check(cmd_valid == 1'b0 && cmd_code == 2'd0, "R1 after release", int'(cmd_valid), 0);
    repeat (5) @(negedge clk);
    p0 = pulses;
    idle(60);
    check(pulses == p0, "R11 zero after reset ignored", pulses - p0, 0);

    // R2: long idle run
    p0 = pulses;
    idle(500);
    check(pulses == p0, "R2 idle ones", pulses - p0, 0);

    // Vector table, R3 varying idle prefix lengths
    for (int i = 0; i < 7; i++) begin
      idle(i * 3 + 1);
      run_frame(VECS[i][49:2], VECS[i][1:0],
                i == 0 ? "R4 idle" : i == 1 ? "R5 pre-idle" : i == 2 ? "R6 boot" :
                "R7 error");
    end

    // R3: odd long prefix before boot frame
    idle(37);
    run_frame(48'h40FFFFFFFAE5, 2'd2, "R3 alignment");

    // R9: zeros straight after a frame are not a start
    idle(4);
    p0 = pulses;
    send_bits(48'h400000000095);
    @(negedge clk); cmd_line = 1'b0;
    @(negedge clk); cmd_line = 1'b0;
    check(cmd_valid == 1'b1 && cmd_code == 2'd0, "R9 frame before zeros", int'(cmd_code), 0);
    @(negedge clk); cmd_line = 1'b0;
    idle(80);
    check(pulses == p0 + 1, "R9 no restart on zero", pulses - p0, 1);

    // R10: known frame while disabled
    en = 1'b0;
    p0 = pulses;
    idle(5);
    send_bits(48'h40FFFFFFFAE5);
    idle(60);
    check(pulses == p0, "R10 disabled frame", pulses - p0, 0);
    en = 1'b1;
    idle(3);

    // R10: enable dropped mid-frame
    p0 = pulses;
    send_bits(48'h40FFFFFFFAE5 & 48'hFFFFFF000000 | 48'h000000FFFFFF);
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    idle(80);
    check(pulses >= p0, "R10 abort sanity", pulses - p0, 0);
    p0 = pulses;
    idle(2);
    send_bits(48'h40F0F0F0F0FD);
    en = 1'b0;
    @(negedge clk); cmd_line = 1'b1;
    en = 1'b1;
    idle(60);
    check(pulses == p0, "R10 aborted frame", pulses - p0, 0);

    // recovery after abort
    idle(2);
    run_frame(48'h40F0F0F0F0FD, 2'd1, "R5 after abort");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule